// File: doc/BRIEF.md
# Insertion Sorted Order Book

This block holds the resting buy orders of a single instrument in on-chip storage and keeps them ranked at all times, highest price first. Orders at the same price keep their arrival order. Each stored entry carries an order reference, a share quantity and a limit price.

Two commands arrive on one valid/ready input. The add command ranks a new order. The sequencer starts at the tail of the list and walks toward the head. Each cycle it compares one stored entry against the new price and moves that entry down one slot, until it finds the slot where the new order belongs. The dump command streams the whole list over a valid/ready output, best price first, and flags the final beat. Because the storage is always ranked, a dump needs no sorting pass. An add arriving when every slot is taken is refused, and a one-cycle overflow pulse reports the refusal.

The command input reports busy for the whole duration of an add's walk and of a dump. A downstream consumer can stall the output at any beat.

Top module: `ob_book`

## Requirements
- R1: After reset, `book_count` is 0, `cmd_ready` is 1, `out_valid` is 0 and `add_overflow` is 0.
- R2: The entries of a dump come out in non-increasing price order.
- R3: A newly added order whose price equals that of stored orders is placed after all of them (first in, first out among equal prices).
- R4: An accepted add holds `cmd_ready` low for exactly k+1 cycles, where k is the number of stored entries whose price is strictly below the new price.
- R5: An add accepted when `book_count` equals DEPTH is refused. `add_overflow` is high for exactly one cycle, in the cycle after acceptance, and the count and stored contents do not change.
- R6: A dump of a non-empty book (`cmd_op` = 1; `cmd_op` = 0 is add) gives exactly `book_count` beats, rank 0 first. Each beat carries the reference, quantity and price of its entry. `out_last` is high only on the final beat and `out_empty` is 0.
- R7: A dump of an empty book gives a single beat with `out_empty` = 1, `out_last` = 1 and all data fields 0.
- R8: While `out_valid` is high and `out_ready` is low, the beat on the output does not change in the next cycle.
- R9: `book_count` rises by one for each add that is not refused, never exceeds DEPTH, and is left unchanged by a dump.
- R10: `cmd_ready` is low from the cycle after a dump is accepted until its final beat has been taken, and high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_op | input | 1 | 0 = add order, 1 = dump all orders |
| cmd_ref | input | REF_W | Order reference of an add |
| cmd_qty | input | QTY_W | Share quantity of an add |
| cmd_price | input | PRICE_W | Limit price of an add |
| out_valid | output | 1 | Dump beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_ref | output | REF_W | Order reference of the beat |
| out_qty | output | QTY_W | Share quantity of the beat |
| out_price | output | PRICE_W | Price of the beat |
| out_last | output | 1 | Final beat of the dump |
| out_empty | output | 1 | Book was empty; beat carries no order |
| add_overflow | output | 1 | One-cycle pulse: add refused, book full |
| book_count | output | $clog2(DEPTH+1) | Number of stored orders |

## Verification
The bench builds the block with DEPTH set to 8 and 32-bit fields. The small depth lets a short directed run fill the book, so the refused-add path and the overflow pulse can be reached and checked, and a later dump can show that the contents stayed intact. With eight slots the bench can also cover inserts at the head (every entry shifted), at the tail (no shift) and between equal prices, and check the exact busy length of each. Dumps run with the consumer always ready, with alternate stalls, and with two stalls in every three cycles.

// File: rtl/ob_pkg.sv
package ob_pkg;

  // Sequencer state
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_DUMP = 2'd2
  } ob_state_e;

  // Command opcode carried on cmd_op
  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_DUMP = 1'b1
  } ob_op_e;

endpackage

// File: rtl/ob_rst_sync.sv
module ob_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ob_store.sv
module ob_store #(
  parameter int DEPTH = 1000,
  parameter int W     = 96,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] slot_q [DEPTH];

  // Storage array: written one slot per cycle, no reset on data
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_addr];

endmodule

// File: rtl/ob_seq.sv
module ob_seq
  import ob_pkg::*;
#(
  parameter int DEPTH   = 1000,
  parameter int REF_W   = 32,
  parameter int QTY_W   = 32,
  parameter int PRICE_W = 32,
  localparam int EW     = REF_W + QTY_W + PRICE_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_op,
  input  logic [REF_W-1:0]   cmd_ref,
  input  logic [QTY_W-1:0]   cmd_qty,
  input  logic [PRICE_W-1:0] cmd_price,
  output logic [AW-1:0]      rd_addr,
  input  logic [EW-1:0]      rd_data,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [EW-1:0]      wr_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_last,
  output logic               out_empty,
  output logic               add_overflow,
  output logic [CW-1:0]      book_count
);

  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  ob_state_e         state_q, state_d;
  logic [CW-1:0]     ptr_q, ptr_d;
  logic              ptr_en;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;
  logic              ovf_q, ovf_d;
  logic [EW-1:0]     new_q;
  logic              new_en;
  logic [CW-1:0]     ptr_prev;
  logic              new_outranks;
  logic              dump_empty;
  logic              dump_last;

  // Slot above the walking pointer, clamped at the head
  assign ptr_prev     = (ptr_q == '0) ? '0 : (ptr_q - CNT_ONE);
  assign rd_addr      = (state_q == ST_DUMP) ? ptr_q[AW-1:0] : ptr_prev[AW-1:0];

  // Buy side: a strictly higher price moves ahead; equal price stays behind
  assign new_outranks = new_q[PRICE_W-1:0] > rd_data[PRICE_W-1:0];

  assign dump_empty   = (cnt_q == '0);
  assign dump_last    = dump_empty || ((ptr_q + CNT_ONE) == cnt_q);

  assign cmd_ready    = (state_q == ST_IDLE);
  assign out_valid    = (state_q == ST_DUMP);
  assign out_last     = out_valid && dump_last;
  assign out_empty    = out_valid && dump_empty;
  assign add_overflow = ovf_q;
  assign book_count   = cnt_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    ovf_d   = 1'b0;
    new_en  = 1'b0;
    wr_en   = 1'b0;
    wr_addr = ptr_q[AW-1:0];
    wr_data = new_q;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (ob_op_e'(cmd_op) == OP_DUMP) begin
            state_d = ST_DUMP;
            ptr_d   = '0;
            ptr_en  = 1'b1;
          end else if (cnt_q == CNT_FULL) begin
            ovf_d = 1'b1;
          end else begin
            new_en  = 1'b1;
            ptr_d   = cnt_q;
            ptr_en  = 1'b1;
            state_d = ST_ADD;
          end
        end
      end

      ST_ADD: begin
        wr_en = 1'b1;
        if ((ptr_q == '0) || !new_outranks) begin
          // Insertion slot found: place the new order
          wr_data = new_q;
          cnt_d   = cnt_q + CNT_ONE;
          cnt_en  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          // Move the lower-priced entry one slot toward the tail
          wr_data = rd_data;
          ptr_d   = ptr_prev;
          ptr_en  = 1'b1;
        end
      end

      ST_DUMP: begin
        if (out_ready) begin
          if (dump_last) begin
            state_d = ST_IDLE;
          end else begin
            ptr_d  = ptr_q + CNT_ONE;
            ptr_en = 1'b1;
          end
        end
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
      if (ptr_en) begin
        ptr_q <= ptr_d;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // Pending order held for the length of its walk
  always_ff @(posedge clk) begin
    if (new_en) begin
      new_q <= {cmd_ref, cmd_qty, cmd_price};
    end
  end

endmodule

// File: rtl/ob_book.sv
module ob_book #(
  parameter int DEPTH   = 1000,
  parameter int REF_W   = 32,
  parameter int QTY_W   = 32,
  parameter int PRICE_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_op,
  input  logic [REF_W-1:0]           cmd_ref,
  input  logic [QTY_W-1:0]           cmd_qty,
  input  logic [PRICE_W-1:0]         cmd_price,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [REF_W-1:0]           out_ref,
  output logic [QTY_W-1:0]           out_qty,
  output logic [PRICE_W-1:0]         out_price,
  output logic                       out_last,
  output logic                       out_empty,
  output logic                       add_overflow,
  output logic [$clog2(DEPTH+1)-1:0] book_count
);

  localparam int EW = REF_W + QTY_W + PRICE_W;
  localparam int AW = $clog2(DEPTH);

  logic          rst_n_int;
  logic [AW-1:0] rd_addr;
  logic [EW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [EW-1:0] wr_data;

  ob_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  ob_store #(
    .DEPTH(DEPTH),
    .W    (EW),
    .AW   (AW)
  ) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  ob_seq #(
    .DEPTH  (DEPTH),
    .REF_W  (REF_W),
    .QTY_W  (QTY_W),
    .PRICE_W(PRICE_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_ref     (cmd_ref),
    .cmd_qty     (cmd_qty),
    .cmd_price   (cmd_price),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_last    (out_last),
    .out_empty   (out_empty),
    .add_overflow(add_overflow),
    .book_count  (book_count)
  );

  // Output fields: zero on the empty-book beat and outside a dump
  always_comb begin
    if (out_valid && !out_empty) begin
      out_price = rd_data[PRICE_W-1:0];
      out_qty   = rd_data[PRICE_W+QTY_W-1:PRICE_W];
      out_ref   = rd_data[EW-1:PRICE_W+QTY_W];
    end else begin
      out_price = '0;
      out_qty   = '0;
      out_ref   = '0;
    end
  end

endmodule

// File: rtl/ob_book_chk.sv
module ob_book_chk #(
  parameter int DEPTH   = 1000,
  parameter int REF_W   = 32,
  parameter int QTY_W   = 32,
  parameter int PRICE_W = 32,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [REF_W-1:0]   out_ref,
  input logic [QTY_W-1:0]   out_qty,
  input logic [PRICE_W-1:0] out_price,
  input logic               out_last,
  input logic               out_empty,
  input logic               add_overflow,
  input logic [CW-1:0]      book_count
);

  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  // Price of the previously taken beat within the current dump
  logic               prev_vld_q;
  logic [PRICE_W-1:0] prev_price_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld_q   <= 1'b0;
      prev_price_q <= '0;
    end else if (out_valid && out_ready) begin
      prev_vld_q   <= !out_last;
      prev_price_q <= out_price;
    end
  end

  // R2: ranked output
  a_r2_desc_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_vld_q) |-> (out_price <= prev_price_q));

  // R5: refusal only when full
  a_r5_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    add_overflow |-> (book_count == CNT_FULL));

  // R5: refusal leaves the count alone
  a_r5_ovf_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    add_overflow |-> (book_count == $past(book_count)));

  // R5: single-cycle pulse
  a_r5_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    add_overflow |=> !add_overflow);

  // R7: empty beat is the only beat
  a_r7_empty_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_empty) |-> (out_last && (out_price == '0) && (book_count == '0)));

  // R8: stalled beat holds
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ref) && $stable(out_qty)
                                   && $stable(out_price) && $stable(out_last)));

  // R9: bounded occupancy
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    book_count <= CNT_FULL);

  // R9: occupancy only steps up by one
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (book_count == $past(book_count)) || (book_count == ($past(book_count) + CNT_ONE)));

  // R10: command side busy during a dump
  a_r10_busy_dump: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);

endmodule

bind ob_book ob_book_chk #(
  .DEPTH  (DEPTH),
  .REF_W  (REF_W),
  .QTY_W  (QTY_W),
  .PRICE_W(PRICE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_ref     (out_ref),
  .out_qty     (out_qty),
  .out_price   (out_price),
  .out_last    (out_last),
  .out_empty   (out_empty),
  .add_overflow(add_overflow),
  .book_count  (book_count)
);

// File: tb/ob_book_bench.sv
`timescale 1ns/1ps
module ob_book_bench;

  localparam int DEPTH = 8;
  localparam int RW    = 32;
  localparam int QW    = 32;
  localparam int PW    = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic          cmd_op;
  logic [RW-1:0] cmd_ref;
  logic [QW-1:0] cmd_qty;
  logic [PW-1:0] cmd_price;
  logic          out_valid;
  logic          out_ready;
  logic [RW-1:0] out_ref;
  logic [QW-1:0] out_qty;
  logic [PW-1:0] out_price;
  logic          out_last;
  logic          out_empty;
  logic          add_overflow;
  logic [CW-1:0] book_count;

  ob_book #(
    .DEPTH(DEPTH), .REF_W(RW), .QTY_W(QW), .PRICE_W(PW)
  ) u_ob_book (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_ref(cmd_ref), .cmd_qty(cmd_qty), .cmd_price(cmd_price),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_ref(out_ref), .out_qty(out_qty), .out_price(out_price),
    .out_last(out_last), .out_empty(out_empty),
    .add_overflow(add_overflow), .book_count(book_count)
  );

  // 200 MHz clock
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk;
  int n_fail;

  // Reference model of the ranked book
  int m_ref   [DEPTH];
  int m_qty   [DEPTH];
  int m_price [DEPTH];
  int m_cnt;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = 1'b0;
    cmd_ref   = '0;
    cmd_qty   = '0;
    cmd_price = '0;
    out_ready = 1'b0;
    m_cnt     = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 count",     book_count,   0);
    check("R1 cmd_ready", cmd_ready,    1);
    check("R1 out_valid", out_valid,    0);
    check("R1 overflow",  add_overflow, 0);
  endtask

  task automatic issue(input bit op, input int r, input int q, input int p);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_ref   = RW'(r);
    cmd_qty   = QW'(q);
    cmd_price = PW'(p);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Add into a book with room: check busy length and count, update model
  task automatic t_add(input int r, input int q, input int p);
    int pos;
    int k;
    int busy;
    pos = 0;
    for (int i = 0; i < m_cnt; i++) if (m_price[i] >= p) pos++;
    k = m_cnt - pos;
    issue(1'b0, r, q, p);
    busy = 0;
    while (!cmd_ready && busy < 5000) begin
      busy++;
      @(negedge clk);
    end
    check("R4 busy cycles", busy, k + 1);
    for (int i = m_cnt; i > pos; i--) begin
      m_ref[i]   = m_ref[i-1];
      m_qty[i]   = m_qty[i-1];
      m_price[i] = m_price[i-1];
    end
    m_ref[pos]   = r;
    m_qty[pos]   = q;
    m_price[pos] = p;
    m_cnt++;
    check("R9 count after add", book_count, m_cnt);
    check("R5 no overflow with room", add_overflow, 0);
  endtask

  // Add into a full book: expect a one-cycle refusal pulse
  task automatic t_add_full(input int r, input int q, input int p);
    issue(1'b0, r, q, p);
    check("R5 overflow pulse high", add_overflow, 1);
    check("R5 stays ready",         cmd_ready,    1);
    check("R5 count unchanged",     book_count,   m_cnt);
    @(negedge clk);
    check("R5 overflow pulse ends", add_overflow, 0);
    check("R5 count still same",    book_count,   m_cnt);
  endtask

  // Dump with a consumer stall pattern: 0 always ready, 1 alternate, 2 two of three stalled
  task automatic t_dump(input int mode);
    int idx;
    int cyc;
    bit rdy;
    bit stalled;
    bit done;
    issue(1'b1, 0, 0, 0);
    idx     = 0;
    cyc     = 0;
    stalled = 1'b0;
    done    = 1'b0;
    while (!done && cyc < 1000) begin
      check("R6 beat valid", out_valid, 1);
      check("R10 busy in dump", cmd_ready, 0);
      if (m_cnt == 0) begin
        check("R7 empty flag", out_empty, 1);
        check("R7 last flag",  out_last,  1);
        check("R7 price zero", out_price, 0);
        check("R7 ref zero",   out_ref,   0);
        check("R7 qty zero",   out_qty,   0);
      end else begin
        check(stalled ? "R8 held price" : "R2 price", out_price, m_price[idx]);
        check(stalled ? "R8 held ref" : "R3 R6 ref", out_ref, m_ref[idx]);
        check("R6 qty",   out_qty,   m_qty[idx]);
        check("R6 last",  out_last,  (idx == m_cnt - 1) ? 1 : 0);
        check("R6 empty", out_empty, 0);
      end
      case (mode)
        0:       rdy = 1'b1;
        1:       rdy = (cyc % 2) == 1;
        default: rdy = (cyc % 3) == 2;
      endcase
      out_ready = rdy;
      @(negedge clk);
      cyc++;
      stalled = !rdy;
      if (rdy) begin
        if (m_cnt == 0 || idx == m_cnt - 1) done = 1'b1;
        else idx++;
      end
    end
    out_ready = 1'b0;
    check("R6 dump ended", out_valid, 0);
    check("R10 ready after dump", cmd_ready, 1);
    check("R9 dump keeps count", book_count, m_cnt);
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    t_reset();
    t_dump(0);              // empty book
    t_add(1, 10, 100);      // first entry
    t_add(2, 20, 120);      // goes ahead of 100
    t_add(3, 30, 90);       // tail, no shift
    t_add(4, 40, 120);      // equal to ref 2, lands behind it
    t_add(5, 50, 110);      // middle
    t_dump(1);
    t_add(6, 60, 130);      // head, every entry moves
    t_add(7, 70, 80);       // tail
    t_add(8, 80, 110);      // equal to ref 5, fills the book
    check("R9 full count", book_count, DEPTH);
    t_add_full(9, 90, 200);
    t_dump(2);              // contents unchanged by the refusal
    t_add_full(10, 99, 50);
    t_dump(0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule